// File: doc/BRIEF.md
# DMA Address Boundary Pause Controller

This block sits inside the single-address DMA engine of an SD-style host controller. It holds the running system memory address. Each beat that the data mover accepts advances the address by a fixed number of bytes. Software picks a power-of-two buffer size, from 4 KB up to 512 KB. When a beat carries the address across a buffer boundary, the block stops accepting beats and raises a sticky DMA interrupt. Software then writes a fresh system address, and the transfer resumes from that address.

The block also holds the 12-bit block size, which gives the bytes per block. Zero means no data moves, and 2048 is the largest legal size. The block size is locked while a transaction runs: writes are dropped and reads return zero. The boundary pause is active only while the transfer-mode DMA enable is high. If the final beat of a transfer lands exactly on a boundary, completion wins and no pause or interrupt happens.

Top module: `dma_boundary_pause`

## Requirements
- R1: After reset the system address is 0, the boundary code is 0, the block size is 0, `dmaPause` is low, `dmaIrq` is low and `beatReady` is high.
- R2: While not paused, `beatReady` is high. A beat with `beatValid` high advances the system address by 4 bytes at that clock edge.
- R3: Boundary code c (0..7) selects a buffer of 4096·2^c bytes. An accepted beat whose address increment carries out of address bit 11+c is a boundary beat. Only a carry out of the selected bit counts; for example, with code 1 a crossing of an odd 4 KB line does not pause.
- R4: After a boundary beat, from the next clock `dmaPause` and `dmaIrq` are high and `beatReady` is low. This happens only while `dmaEnable` is high; with `dmaEnable` low a boundary beat causes neither a pause nor an interrupt.
- R5: While paused, `beatValid` is ignored and the system address does not change.
- R6: A write to the system address register clears the pause at that edge. Beats then continue from the written address.
- R7: The interrupt status (register 2, bit 0) is sticky. Writing 1 to bit 0 clears it, and writing 0 leaves it unchanged. Once cleared, it stays low through beats that do not cross a boundary and sets again only at the next boundary beat.
- R8: A boundary beat that has `lastBeat` high causes no pause and no interrupt.
- R9: While `xferActive` is high, block size writes are ignored and block size reads return 0; the boundary code stays writable. Once `xferActive` is low, the stored size reads back.
- R10: The register map is as follows; reads are combinational from `regAddr`, and address 3 reads as zero.
  - Address 0: the 32-bit system address.
  - Address 1: configuration, with the block size in bits [11:0] and the boundary code in bits [18:16].
  - Address 2: status, with the interrupt flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data |
| xferActive | input | 1 | A transaction is running |
| dmaEnable | input | 1 | DMA enable from transfer mode control |
| beatValid | input | 1 | Data mover requests an address advance |
| lastBeat | input | 1 | The offered beat ends the transfer |
| beatReady | output | 1 | Advance accepted (low while paused) |
| sysAddr | output | 32 | Current system memory address |
| dmaPause | output | 1 | Transfer halted at a boundary |
| dmaIrq | output | 1 | Sticky DMA boundary interrupt |

## Verification
Register reads are combinational, so a read result is due in the same cycle that `regAddr` is driven. An accepted beat or a register write shows up on `sysAddr`, `dmaPause`, `dmaIrq` and `beatReady` one clock edge later. The bench changes inputs on the falling edge and lets exactly one rising edge pass before it samples. It then reads registers a short delay after setting `regAddr`, still away from any rising edge. The paused-beat and write-zero cases are checked by reading the address and status back through the register port before any further stimulus.

// File: rtl/dmabnd_pkg.sv
package dmabnd_pkg;
  localparam int DATA_W     = 32;
  localparam int BEAT_BYTES = 4;
  localparam int BASE_BIT   = 11;
  localparam int CODE_W     = 3;
  localparam int SIZE_W     = 12;
  localparam int CODE_LSB   = 16;

  typedef enum logic [1:0] {
    REG_SYSADDR = 2'd0,
    REG_CONFIG  = 2'd1,
    REG_STATUS  = 2'd2
  } regSel_e;

  typedef struct packed {
    logic advance;
    logic loadAddr;
    logic loadCfg;
  } ctrlStrobes_t;
endpackage

// File: rtl/dmabnd_datapath.sv
module dmabnd_datapath
  import dmabnd_pkg::*;
#(
  parameter int ADDR_W   = DATA_W,
  parameter int BEAT_B   = BEAT_BYTES,
  parameter int BASE     = BASE_BIT,
  parameter int CODE_BITS = CODE_W,
  parameter int SIZE_BITS = SIZE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [ADDR_W-1:0]  wrData,
  input  logic [1:0]         rdSel,
  input  logic               xferActive,
  input  logic               irqStatus,
  output logic               crossing,
  output logic [ADDR_W-1:0]  addrOut,
  output logic [ADDR_W-1:0]  rdData
);
  localparam int NUM_CODES  = 1 << CODE_BITS;
  localparam int BEAT_SHIFT = $clog2(BEAT_B);

  logic [ADDR_W-1:0]    addrQ;
  logic [SIZE_BITS-1:0] sizeQ;
  logic [CODE_BITS-1:0] codeQ;
  logic [NUM_CODES-1:0] crossVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      sizeQ <= '0;
      codeQ <= '0;
    end else begin
      if (strb.loadAddr)
        addrQ <= wrData;
      else if (strb.advance)
        addrQ <= addrQ + ADDR_W'(BEAT_B);
      if (strb.loadCfg) begin
        codeQ <= wrData[CODE_LSB +: CODE_BITS];
        if (!xferActive)
          sizeQ <= wrData[SIZE_BITS-1:0];
      end
    end
  end

  // A beat carries out of bit k exactly when bits [k:beat] are all ones.
  for (genvar i = 0; i < NUM_CODES; i++) begin : g_cross
    assign crossVec[i] = &addrQ[BASE+i:BEAT_SHIFT];
  end
  assign crossing = crossVec[codeQ];
  assign addrOut  = addrQ;

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      REG_SYSADDR: rdData = addrQ;
      REG_CONFIG: begin
        rdData[CODE_LSB +: CODE_BITS] = codeQ;
        rdData[SIZE_BITS-1:0]         = xferActive ? '0 : sizeQ;
      end
      REG_STATUS:  rdData[0] = irqStatus;
      default:     rdData = '0;
    endcase
  end

  a_r9_size_locked: assert property (@(posedge clk) disable iff (!rstN)
    $past(xferActive) |-> $stable(sizeQ));
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.advance) && !$past(strb.loadAddr)) |-> addrQ == $past(addrQ) + ADDR_W'(BEAT_B));
endmodule

// File: rtl/dmabnd_ctrl.sv
module dmabnd_ctrl
  import dmabnd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic [1:0]   regAddr,
  input  logic         clrBit,
  input  logic         beatValid,
  input  logic         lastBeat,
  input  logic         dmaEnable,
  input  logic         crossing,
  output ctrlStrobes_t strb,
  output logic         pauseOut,
  output logic         irqOut
);
  logic pauseQ;
  logic irqQ;
  logic stopHere;
  logic clrIrq;

  always_comb begin
    strb.advance  = beatValid && !pauseQ;
    strb.loadAddr = regWrEn && (regAddr == REG_SYSADDR);
    strb.loadCfg  = regWrEn && (regAddr == REG_CONFIG);
  end

  // Completion (lastBeat) outranks the boundary stop.
  assign stopHere = strb.advance && crossing && dmaEnable && !lastBeat;
  assign clrIrq   = regWrEn && (regAddr == REG_STATUS) && clrBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pauseQ <= 1'b0;
      irqQ   <= 1'b0;
    end else begin
      if (strb.loadAddr)
        pauseQ <= 1'b0;
      else if (stopHere)
        pauseQ <= 1'b1;
      if (stopHere)
        irqQ <= 1'b1;
      else if (clrIrq)
        irqQ <= 1'b0;
    end
  end

  assign pauseOut = pauseQ;
  assign irqOut   = irqQ;

  a_r4_pause_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pauseQ) |-> $past(dmaEnable && beatValid));
  a_r5_hold_when_paused: assert property (@(posedge clk) disable iff (!rstN)
    pauseQ |-> !strb.advance);
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqQ && !clrIrq) |=> irqQ);
  a_r8_last_no_irq: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> !$past(lastBeat));
  a_r6_write_resumes: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadAddr |=> !pauseQ);
endmodule

// File: rtl/dma_boundary_pause.sv
module dma_boundary_pause
  import dmabnd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              xferActive,
  input  logic              dmaEnable,
  input  logic              beatValid,
  input  logic              lastBeat,
  output logic              beatReady,
  output logic [DATA_W-1:0] sysAddr,
  output logic              dmaPause,
  output logic              dmaIrq
);
  ctrlStrobes_t strb;
  logic crossing;
  logic pauseW;
  logic irqW;

  dmabnd_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .clrBit    (regWrData[0]),
    .beatValid (beatValid),
    .lastBeat  (lastBeat),
    .dmaEnable (dmaEnable),
    .crossing  (crossing),
    .strb      (strb),
    .pauseOut  (pauseW),
    .irqOut    (irqW)
  );

  dmabnd_datapath #(
    .ADDR_W    (DATA_W),
    .BEAT_B    (BEAT_BYTES),
    .BASE      (BASE_BIT),
    .CODE_BITS (CODE_W),
    .SIZE_BITS (SIZE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (regWrData),
    .rdSel      (regAddr),
    .xferActive (xferActive),
    .irqStatus  (irqW),
    .crossing   (crossing),
    .addrOut    (sysAddr),
    .rdData     (regRdData)
  );

  assign beatReady = !pauseW;
  assign dmaPause  = pauseW;
  assign dmaIrq    = irqW;
endmodule

// File: tb/dma_boundary_pause_tb.sv
module dma_boundary_pause_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic xferActive = 1'b0;
  logic dmaEnable = 1'b1;
  logic beatValid = 1'b0;
  logic lastBeat = 1'b0;
  logic beatReady;
  logic [31:0] sysAddr;
  logic dmaPause;
  logic dmaIrq;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_boundary_pause dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .xferActive(xferActive),
    .dmaEnable(dmaEnable), .beatValid(beatValid), .lastBeat(lastBeat),
    .beatReady(beatReady), .sysAddr(sysAddr), .dmaPause(dmaPause), .dmaIrq(dmaIrq)
  );

  // {boundary code, buffer bytes}
  localparam logic [34:0] VEC [8] = '{
    {3'd0, 32'h0000_1000}, {3'd1, 32'h0000_2000},
    {3'd2, 32'h0000_4000}, {3'd3, 32'h0000_8000},
    {3'd4, 32'h0001_0000}, {3'd5, 32'h0002_0000},
    {3'd6, 32'h0004_0000}, {3'd7, 32'h0008_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic beat(input logic last);
    beatValid = 1'b1; lastBeat = last;
    @(negedge clk);
    beatValid = 1'b0; lastBeat = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] rv;
    logic [31:0] bnd;
    logic [31:0] startA;
    logic [2:0]  code;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdReg(2'd0, rv); chk("R1 addr", rv, 32'h0);
    rdReg(2'd1, rv); chk("R1 config", rv, 32'h0);
    chk("R1 pause", {31'b0, dmaPause}, 32'h0);
    chk("R1 irq", {31'b0, dmaIrq}, 32'h0);
    chk("R1 ready", {31'b0, beatReady}, 32'h1);

    // Table walk over every boundary code
    for (int i = 0; i < 8; i++) begin
      code = VEC[i][34:32];
      bnd  = VEC[i][31:0];
      startA = 3 * bnd - 8;
      wrReg(2'd1, (32'(code) << 16) | 32'd512);
      rdReg(2'd1, rv); chk("R10 config readback", rv, (32'(code) << 16) | 32'd512);
      wrReg(2'd0, startA);
      beat(1'b0);
      chk("R2 step", sysAddr, startA + 4);
      chk("R2 no pause before boundary", {31'b0, dmaPause}, 32'h0);
      beat(1'b0);
      chk("R3 addr at boundary", sysAddr, 3 * bnd);
      chk("R4 pause", {31'b0, dmaPause}, 32'h1);
      chk("R4 irq", {31'b0, dmaIrq}, 32'h1);
      chk("R4 ready low", {31'b0, beatReady}, 32'h0);
      beat(1'b0);
      rdReg(2'd0, rv); chk("R5 addr held while paused", rv, 3 * bnd);
      wrReg(2'd2, 32'h1);
      rdReg(2'd2, rv); chk("R7 irq cleared", rv, 32'h0);
      wrReg(2'd0, 5 * bnd + 16);
      chk("R6 pause cleared", {31'b0, dmaPause}, 32'h0);
      beat(1'b0);
      chk("R6 resume from new address", sysAddr, 5 * bnd + 20);
    end

    // R3: code 1 ignores an odd 4 KB line
    wrReg(2'd1, 32'h0001_0000);
    wrReg(2'd0, 32'h0000_2FFC);
    beat(1'b0);
    chk("R3 no pause on 4K line with code 1", {31'b0, dmaPause}, 32'h0);
    chk("R3 addr", sysAddr, 32'h0000_3000);

    // R4: DMA disabled, no pause
    wrReg(2'd1, 32'h0);
    dmaEnable = 1'b0;
    wrReg(2'd0, 32'h0000_0FFC);
    beat(1'b0);
    chk("R4 disabled no pause", {31'b0, dmaPause}, 32'h0);
    chk("R4 disabled no irq", {31'b0, dmaIrq}, 32'h0);
    dmaEnable = 1'b1;

    // R8: final beat on boundary
    wrReg(2'd0, 32'h0000_1FFC);
    beat(1'b1);
    chk("R8 last beat no pause", {31'b0, dmaPause}, 32'h0);
    chk("R8 last beat no irq", {31'b0, dmaIrq}, 32'h0);

    // R7: write 0 keeps flag, no re-fire without carry
    wrReg(2'd0, 32'h0000_2FFC);
    beat(1'b0);
    chk("R7 irq set", {31'b0, dmaIrq}, 32'h1);
    wrReg(2'd2, 32'h0);
    rdReg(2'd2, rv); chk("R7 write zero keeps irq", rv, 32'h1);
    wrReg(2'd2, 32'h1);
    wrReg(2'd0, 32'h0000_3100);
    beat(1'b0); beat(1'b0);
    chk("R7 no re-fire without carry", {31'b0, dmaIrq}, 32'h0);

    // R9: block size locked during transfer
    wrReg(2'd1, 32'd2048);
    xferActive = 1'b1;
    wrReg(2'd1, 32'h0003_0064);
    rdReg(2'd1, rv); chk("R9 size reads zero, code writable", rv, 32'h0003_0000);
    xferActive = 1'b0;
    rdReg(2'd1, rv); chk("R9 size kept", rv, 32'h0003_0800);
    rdReg(2'd3, rv); chk("R10 unused address", rv, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule